// File: doc/BRIEF.md
# Chiplet Control Register Bank

This block holds the 64-bit control, configuration and status words of one chiplet and serves them over a simple strobe-based register bus. Each access carries a byte address. The low three bits of that address are dropped, and the remaining bits form a word index. That index selects a plain register, a set-bits alias, a clear-bits alias, or nothing at all.

Six control words and two configuration words can each be reached at three indices. The first index loads the word directly. The second ORs the write data into it. The third clears every bit that is one in the write data. Four further words (status, mask, protect-mode and atomic-lock) have a single index each and are loaded and read back directly.

Reads return registered data one cycle after the read strobe. Reads from the write-only aliases and accesses to unmapped indices raise a one-cycle error pulse in that same response cycle. The response path has no back-pressure: the requester must accept `rd_data`, `rd_valid` and `err` in the cycle they appear, because the next strobe overwrites them. Read and write strobes are never raised together.

Top module: `chiplet_ctl_bank`

## Requirements
- R1: After reset every register reads as zero, and `rd_valid` and `err` are low.
- R2: A read strobe sampled on one clock edge produces `rd_valid` high for exactly the following cycle, with `rd_data` valid in that cycle. Cycles without a read strobe have `rd_valid` low. `rd_en` and `wr_en` are never high together.
- R3: A write to control index 0x00..0x05 or configuration index 0x08/0x09 replaces that register with the write data on the sampling edge and raises no error.
- R4: A write to index 0x10+k (k = 0..5), 0x18 or 0x19 sets bits in the target (control k, configuration 0, configuration 1 respectively): target becomes target OR data. No other register changes.
- R5: A write to index 0x20+k (k = 0..5), 0x28 or 0x29 clears bits in the target: target becomes target AND NOT data. No other register changes.
- R6: A read from any set or clear alias index returns all ones with `err` high, and changes no register.
- R7: Index 0x100 (status), 0x101 (mask), 0x3FE (protect mode) and 0x3FF (atomic lock) are plain read/write words.
- R8: A read from an unmapped index returns all ones with `err` high for that one response cycle.
- R9: A write to an unmapped index changes no register and raises `err` for the one cycle after the strobe. Writes to mapped indices never raise `err`.
- R10: Byte-address bits [2:0] do not take part in decode. The word index is `addr[12:3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 13 | Byte address; bits [12:3] are the word index |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| err | output | 1 | One-cycle pulse for an unmapped access or an alias read |

## Verification
Distinct write patterns go to every plain word so that a swapped decode or crossed slot shows up as a wrong value at a neighbour. The set and clear aliases are driven with data that overlaps the target only partly. Ordinary overwrite, OR and AND-NOT therefore each leave a different result. Alias reads, unmapped reads and unmapped writes are each followed by a full read-back of all twelve words, which separates "ignored" from "silently corrupted". Non-zero low address bits check that the byte offset never leaks into decode.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned ADDR_W  = 13;
  localparam int unsigned BYTE_LO = 3;
  localparam int unsigned IDX_W   = ADDR_W - BYTE_LO;
  localparam int unsigned N_CTRL  = 6;
  localparam int unsigned N_CFG   = 2;
  localparam int unsigned N_PLAIN = 4;
  localparam int unsigned N_ALIAS = N_CTRL + N_CFG;
  localparam int unsigned N_SLOT  = N_ALIAS + N_PLAIN;
  localparam int unsigned SLOT_W  = $clog2(N_SLOT);

  localparam logic [IDX_W-1:0] CTRL_BASE = 10'h000;
  localparam logic [IDX_W-1:0] CFG_BASE  = 10'h008;
  localparam logic [IDX_W-1:0] SET_OFS   = 10'h010;
  localparam logic [IDX_W-1:0] CLR_OFS   = 10'h020;
  localparam logic [IDX_W-1:0] PLAIN_IDX [N_PLAIN] = '{10'h100, 10'h101, 10'h3FE, 10'h3FF};

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } wop_e;
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int unsigned IW  = IDX_W,
  parameter int unsigned NC  = N_CTRL,
  parameter int unsigned NF  = N_CFG,
  parameter int unsigned NP  = N_PLAIN,
  parameter int unsigned SW  = SLOT_W
) (
  input  logic [IW-1:0] idx,
  output logic          hit,
  output logic          wonly,
  output wop_e          op,
  output logic [SW-1:0] slot
);
  localparam int unsigned NA = NC + NF;

  logic [IW-1:0] base;

  always_comb begin
    hit   = 1'b0;
    wonly = 1'b0;
    op    = OP_LOAD;
    slot  = '0;
    base  = '0;
    for (int i = 0; i < NA; i++) begin
      if (i < NC) base = CTRL_BASE + IW'(i);
      else        base = CFG_BASE + IW'(i - NC);
      if (idx == base) begin
        hit  = 1'b1;
        slot = SW'(i);
      end else if (idx == base + SET_OFS) begin
        hit   = 1'b1;
        wonly = 1'b1;
        op    = OP_SET;
        slot  = SW'(i);
      end else if (idx == base + CLR_OFS) begin
        hit   = 1'b1;
        wonly = 1'b1;
        op    = OP_CLR;
        slot  = SW'(i);
      end
    end
    for (int j = 0; j < NP; j++) begin
      if (idx == PLAIN_IDX[j]) begin
        hit  = 1'b1;
        slot = SW'(NA + j);
      end
    end
  end
endmodule

// File: rtl/ccr_regbank.sv
module ccr_regbank
  import ccr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = N_SLOT,
  parameter int unsigned NA = N_ALIAS,
  parameter int unsigned SW = SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] slot,
  input  wop_e          op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [NS];

  for (genvar g = 0; g < NS; g++) begin : g_slot
    logic [DW-1:0] q;
    logic [DW-1:0] nxt;
    if (g < NA) begin : g_alias
      always_comb begin
        unique case (op)
          OP_SET:  nxt = q | wdata;
          OP_CLR:  nxt = q & ~wdata;
          default: nxt = wdata;
        endcase
      end
    end else begin : g_plain
      assign nxt = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     q <= '0;
      else if (we && slot == SW'(g))  q <= nxt;
    end
    assign regs[g] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NS; i++)
      if (slot == SW'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/ccr_resp.sv
module ccr_resp #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          hit,
  input  logic          wonly,
  input  logic [DW-1:0] sel_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          err
);
  logic bad_rd, bad_wr;

  assign bad_rd = rd_en && (!hit || wonly);
  assign bad_wr = wr_en && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      err      <= bad_rd || bad_wr;
      if (rd_en) rd_data <= bad_rd ? '1 : sel_data;
    end
  end
endmodule

// File: rtl/chiplet_ctl_bank.sv
module chiplet_ctl_bank
  import ccr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          err
);
  localparam int unsigned IW = AW - BYTE_LO;

  logic [IW-1:0]     idx;
  logic              hit, wonly;
  wop_e              op;
  logic [SLOT_W-1:0] slot;
  logic [DW-1:0]     sel_data;
  logic              unused_byte_lo;

  assign idx            = addr[AW-1:BYTE_LO];
  assign unused_byte_lo = ^addr[BYTE_LO-1:0];

  ccr_decode #(.IW(IW), .NC(N_CTRL), .NF(N_CFG), .NP(N_PLAIN), .SW(SLOT_W)) u_dec (
    .idx(idx), .hit(hit), .wonly(wonly), .op(op), .slot(slot)
  );

  ccr_regbank #(.DW(DW), .NS(N_SLOT), .NA(N_ALIAS), .SW(SLOT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_en && hit), .slot(slot), .op(op),
    .wdata(wr_data), .rdata(sel_data)
  );

  ccr_resp #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .hit(hit),
    .wonly(wonly), .sel_data(sel_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .err(err)
  );
endmodule

// File: rtl/chiplet_ctl_bank_chk.sv
module chiplet_ctl_bank_chk
  import ccr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          err
);
  localparam int unsigned IW = AW - BYTE_LO;

  logic [IW-1:0] ix;
  logic          is_alias, is_plain;

  assign ix = addr[AW-1:BYTE_LO];

  always_comb begin
    is_alias = 1'b0;
    is_plain = 1'b0;
    for (int k = 0; k < N_CTRL; k++) begin
      if (ix == CTRL_BASE + IW'(k)) is_plain = 1'b1;
      if (ix == CTRL_BASE + SET_OFS + IW'(k) || ix == CTRL_BASE + CLR_OFS + IW'(k)) is_alias = 1'b1;
    end
    for (int k = 0; k < N_CFG; k++) begin
      if (ix == CFG_BASE + IW'(k)) is_plain = 1'b1;
      if (ix == CFG_BASE + SET_OFS + IW'(k) || ix == CFG_BASE + CLR_OFS + IW'(k)) is_alias = 1'b1;
    end
    for (int k = 0; k < N_PLAIN; k++)
      if (ix == PLAIN_IDX[k]) is_plain = 1'b1;
  end

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_mapped_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (is_plain || is_alias) |=> !err);
  assert_alias_read_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && is_alias |=> (rd_data == '1) && err);
  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !is_alias && !is_plain |=> (rd_data == '1) && err);
  assert_plain_read_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && is_plain |=> !err);
  assert_unmapped_write_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !is_alias && !is_plain |=> err);
  assert_err_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_en || wr_en));
endmodule

bind chiplet_ctl_bank chiplet_ctl_bank_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rd_data(rd_data), .rd_valid(rd_valid), .err(err)
);

// File: tb/chiplet_ctl_bank_tb_top.sv
module chiplet_ctl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [12:0] addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit          rd;
    logic [63:0] d;
    bit          e;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [63:0] m [12];
  int          slot_idx [12] = '{0, 1, 2, 3, 4, 5, 8, 9, 256, 257, 1022, 1023};

  always #2.5 clk = ~clk;

  chiplet_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .err(err)
  );

  // slot number or -1; op: 0 load, 1 set, 2 clear
  function automatic int map(input int idx, output int op);
    op = 0;
    for (int k = 0; k < 6; k++) begin
      if (idx == k) return k;
      if (idx == k + 16) begin op = 1; return k; end
      if (idx == k + 32) begin op = 2; return k; end
    end
    for (int k = 0; k < 2; k++) begin
      if (idx == 8 + k) return 6 + k;
      if (idx == 24 + k) begin op = 1; return 6 + k; end
      if (idx == 40 + k) begin op = 2; return 6 + k; end
    end
    case (idx)
      256:  return 8;
      257:  return 9;
      1022: return 10;
      1023: return 11;
      default: return -1;
    endcase
  endfunction

  task automatic wr(input int idx, input logic [63:0] d, input string tag,
                    input logic [2:0] lo = 3'd0);
    int s, op;
    exp_t it;
    s = map(idx, op);
    if (s >= 0) begin
      if (op == 0)      m[s] = d;
      else if (op == 1) m[s] = m[s] | d;
      else              m[s] = m[s] & ~d;
    end
    @(negedge clk);
    addr = {idx[9:0], lo}; wr_data = d; wr_en = 1'b1;
    it.rd = 1'b0; it.d = '0; it.e = (s < 0); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, input string tag, input logic [2:0] lo = 3'd0);
    int s, op;
    exp_t it;
    s = map(idx, op);
    it.rd  = 1'b1;
    it.e   = (s < 0) || (op != 0);
    it.d   = it.e ? '1 : m[s];
    it.tag = tag;
    @(negedge clk);
    addr = {idx[9:0], lo}; rd_en = 1'b1;
    q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 12; i++) rd(slot_idx[i], tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && !done) begin
        n_chk++;
        if (q.size() > 0) begin
          exp_t it;
          it = q.pop_front();
          if (rd_valid !== it.rd || err !== it.e || (it.rd && rd_data !== it.d)) begin
            n_fail++;
            $display("FAIL %s: rd_valid=%0b err=%0b rd_data=%h expected rd_valid=%0b err=%0b rd_data=%h",
                     it.tag, rd_valid, err, rd_data, it.rd, it.e, it.d);
          end
        end else if (rd_valid !== 1'b0 || err !== 1'b0) begin
          n_fail++;
          $display("FAIL R2/R9 idle: rd_valid=%0b err=%0b expected 0 0", rd_valid, err);
        end
      end
    end
  end

  initial begin
    #100us;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rd_valid !== 1'b0 || err !== 1'b0 || rd_data !== '0) begin
      n_fail++;
      $display("FAIL R1: rd_valid=%0b err=%0b rd_data=%h expected 0 0 0", rd_valid, err, rd_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    rd_all("R1 reset zero");

    // R3: plain loads, distinct per word
    for (int k = 0; k < 6; k++) wr(k, 64'hC0DE_0000_0000_0000 | 64'(k * 64'h0101_0101), "R3 ctrl load");
    wr(8, 64'h1234_5678_9ABC_DEF0, "R3 cfg0 load");
    wr(9, 64'h0F0F_0F0F_F0F0_F0F0, "R3 cfg1 load");
    rd_all("R3 readback");

    // R4: set aliases with partial overlap
    wr(16 + 3, 64'hFF00_0000_0000_00FF, "R4 set ctrl3");
    wr(24, 64'h0000_FFFF_0000_0000, "R4 set cfg0");
    wr(25, 64'h8000_0000_0000_0001, "R4 set cfg1");
    rd_all("R4 readback");

    // R5: clear aliases with partial overlap
    wr(32 + 2, 64'hC0DE_0000_FFFF_0000, "R5 clear ctrl2");
    wr(32 + 5, 64'hFFFF_FFFF_FFFF_FFFF, "R5 clear ctrl5");
    wr(41, 64'h0F0F_0000_0000_F0F0, "R5 clear cfg1");
    rd_all("R5 readback");

    // R6: alias reads
    rd(16, "R6 read set alias ctrl0");
    rd(37, "R6 read clear alias ctrl5");
    rd(24, "R6 read set alias cfg0");
    rd(40, "R6 read clear alias cfg0");
    rd_all("R6 no change");

    // R7: single-index words
    wr(256, 64'hDEAD_BEEF_0000_0001, "R7 stat");
    wr(257, 64'h5555_AAAA_5555_AAAA, "R7 mask");
    wr(1022, 64'h0000_0000_0000_0003, "R7 protect");
    wr(1023, 64'h8000_0000_0000_0000, "R7 lock");
    rd_all("R7 readback");

    // R8: unmapped reads
    rd(7, "R8 unmapped 0x07");
    rd(10, "R8 unmapped 0x0A");
    rd(48, "R8 unmapped 0x30");
    rd(258, "R8 unmapped 0x102");
    rd(1021, "R8 unmapped 0x3FD");
    rd(512, "R8 unmapped 0x200");

    // R9: unmapped writes ignored
    wr(7, '1, "R9 unmapped write 0x07");
    wr(42, '1, "R9 unmapped write 0x2A");
    wr(1021, '1, "R9 unmapped write 0x3FD");
    wr(64, '1, "R9 unmapped write 0x40");
    rd_all("R9 no change");

    // R10: byte offset bits ignored
    wr(1, 64'h0BAD_F00D_CAFE_0001, "R10 load ctrl1 lo=5", 3'd5);
    rd(1, "R10 read ctrl1 lo=7", 3'd7);
    wr(16 + 1, 64'h00F0, "R10 set ctrl1 lo=3", 3'd3);
    rd(1023, "R10 read lock lo=1", 3'd1);
    rd_all("R10 readback");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule